// File: doc/BRIEF.md
# Per-Pin Interrupt Sense Detector

This block turns eight asynchronous external interrupt pins into eight request lines for a downstream priority stage. Each pin has its own 2-bit sense code held in a 16-bit control word. The code selects one of four conditions:

- the pin being low;
- a high-to-low change;
- a low-to-high change;
- a change in either direction.

After reset every code is zero, so every pin starts in low-level mode.

Each pin is first brought into the clock domain by a two-stage synchronizer. Edges are found by comparing the synchronized value with its value one cycle earlier.

- **Edge modes.** A detected edge sets a per-channel flag. The flag drives the request until software pulses that channel's clear strobe.
- **Level mode.** The request simply mirrors the inverted synchronized pin, and the flag is held clear.
- **Code changes.** Rewriting a channel's code to a new value discards any flag that channel holds.

Top module: `irq_sense_unit`

## Requirements
- R1: The control word is 16 bits wide, and every bit resets to 0. A write updates it at the next clock edge, and rd_data shows the stored word. Channel n is controlled by bits 2n+1:2n.
- R2: While reset is asserted, and after it with all pins high, every request output is 0.
- R3: Code 00 (low level): req[n] is the inverse of pin n, delayed by two clock edges.
- R4: Code 01 (falling): a high-to-low change on pin n sets req[n] at the third clock edge after the change. A low-to-high change is ignored.
- R5: Code 10 (rising): a low-to-high change sets req[n] at the third clock edge after the change. A high-to-low change is ignored.
- R6: Code 11 (both): a change in either direction sets req[n] with the same three-edge latency.
- R7: In an edge mode, a set request holds until clr_strobe[n] is high at a clock edge. It then drops after that edge.
- R8: If a new qualifying edge is detected at the same clock edge as clr_strobe[n], the request stays set.
- R9: A write that changes channel n's code to an edge code leaves req[n] at 0 after that edge, and the change itself produces no request.
- R10: Channels are independent. Stimulus, clears or code changes on one channel leave the other channels' requests unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write enable |
| wr_data | input | 16 | Control word write value |
| rd_data | output | 16 | Current control word |
| pin_async | input | 8 | Asynchronous external interrupt pins |
| clr_strobe | input | 8 | Per-channel clear for latched edge requests |
| req | output | 8 | Per-channel request to the priority stage |

## Verification
The hardest case to reach is a clear strobe that lands on the very clock edge at which a new edge is detected, because the edge becomes visible only after three register stages. The stimulus drives every input on the falling clock edge. It toggles the pin, waits exactly two more falling edges, and then raises the clear strobe for one cycle, so that the clear and the detection share one rising edge. The case of a code change while a flag is set is reached by latching a request first and then rewriting only that channel's code.

// File: rtl/irq_sense_pkg.sv
package irq_sense_pkg;

    localparam int SENSE_W = 2;

    typedef enum logic [SENSE_W-1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_FALL = 2'b01,
        SENSE_RISE = 2'b10,
        SENSE_ANY  = 2'b11
    } sense_e;

endpackage

// File: rtl/irq_sense_ctrl.sv
module irq_sense_ctrl
    import irq_sense_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SENSE_W*NUM_PINS-1:0]     wr_data,
    output logic [SENSE_W*NUM_PINS-1:0]     word_o,
    output logic [NUM_PINS-1:0]             chg_o
);
    localparam int CTRL_W = SENSE_W * NUM_PINS;

    typedef struct packed {
        logic [CTRL_W-1:0] word;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en) begin
            ctrl_d.word = wr_data;
        end
    end

    // a channel sees a change strobe only when its own field takes a new value
    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_chg
        assign chg_o[gi] = wr_en &&
            (wr_data[SENSE_W*gi +: SENSE_W] != ctrl_q.word[SENSE_W*gi +: SENSE_W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign word_o = ctrl_q.word;

endmodule

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic [NUM_PINS-1:0] sync_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0] meta;
        logic [NUM_PINS-1:0] stable;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.meta   = pin_i;
        sync_d.stable = sync_q.meta;
    end

    // pins idle high, so both stages reset to the inactive level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.stable;

endmodule

// File: rtl/irq_sense_chan.sv
module irq_sense_chan
    import irq_sense_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SENSE_W-1:0]  mode_i,
    input  logic                chg_i,
    input  logic                clr_i,
    input  logic                sync_i,
    output logic                req_o
);
    typedef struct packed {
        logic prev;
        logic flag;
    } chan_t;

    chan_t  chan_d, chan_q;
    sense_e mode;
    logic   rise;
    logic   fall;
    logic   hit;

    assign mode = sense_e'(mode_i);
    assign rise = sync_i & ~chan_q.prev;
    assign fall = ~sync_i & chan_q.prev;

    always_comb begin
        unique case (mode)
            SENSE_FALL: hit = fall;
            SENSE_RISE: hit = rise;
            SENSE_ANY:  hit = rise | fall;
            default:    hit = 1'b0;
        endcase
    end

    always_comb begin
        chan_d      = chan_q;
        // prev follows the synchronized pin every cycle, so a code change never sees a stale value
        chan_d.prev = sync_i;
        if (mode == SENSE_LOW || chg_i) begin
            chan_d.flag = 1'b0;
        end else begin
            // detection wins over a simultaneous clear
            chan_d.flag = (chan_q.flag & ~clr_i) | hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '{prev: 1'b1, flag: 1'b0};
        end else begin
            chan_q <= chan_d;
        end
    end

    assign req_o = (mode == SENSE_LOW) ? ~sync_i : chan_q.flag;

endmodule

// File: rtl/irq_sense_unit.sv
module irq_sense_unit
    import irq_sense_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [SENSE_W*NUM_PINS-1:0]  wr_data,
    output logic [SENSE_W*NUM_PINS-1:0]  rd_data,
    input  logic [NUM_PINS-1:0]          pin_async,
    input  logic [NUM_PINS-1:0]          clr_strobe,
    output logic [NUM_PINS-1:0]          req
);
    localparam int CTRL_W = SENSE_W * NUM_PINS;

    logic [CTRL_W-1:0]   word;
    logic [NUM_PINS-1:0] chg;
    logic [NUM_PINS-1:0] sync;

    irq_sense_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .word_o  (word),
        .chg_o   (chg)
    );

    irq_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_async),
        .sync_o (sync)
    );

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_chan
        irq_sense_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .mode_i (word[SENSE_W*gi +: SENSE_W]),
            .chg_i  (chg[gi]),
            .clr_i  (clr_strobe[gi]),
            .sync_i (sync[gi]),
            .req_o  (req[gi])
        );
    end

    assign rd_data = word;

endmodule

// File: rtl/irq_sense_chk.sv
module irq_sense_chk
    import irq_sense_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         wr_en,
    input logic [SENSE_W*NUM_PINS-1:0]  wr_data,
    input logic [SENSE_W*NUM_PINS-1:0]  rd_data,
    input logic [NUM_PINS-1:0]          pin_async,
    input logic [NUM_PINS-1:0]          clr_strobe,
    input logic [NUM_PINS-1:0]          req
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    p_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data == $past(wr_data));

    for (genvar gi = 0; gi < NUM_PINS; gi++) begin : g_chk
        p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (age == 2'd3 && rd_data[SENSE_W*gi +: SENSE_W] == SENSE_LOW)
            |-> req[gi] == !$past(pin_async[gi], 2));

        p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_data[SENSE_W*gi +: SENSE_W] != SENSE_LOW && req[gi]
             && !clr_strobe[gi] && !wr_en) |=> req[gi]);

        p_mode_change_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_data[SENSE_W*gi +: SENSE_W] != rd_data[SENSE_W*gi +: SENSE_W]
             && wr_data[SENSE_W*gi +: SENSE_W] != SENSE_LOW) |=> !req[gi]);
    end

endmodule

bind irq_sense_unit irq_sense_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_data    (rd_data),
    .pin_async  (pin_async),
    .clr_strobe (clr_strobe),
    .req        (req)
);

// File: tb/sim_irq_sense_unit.sv
module sim_irq_sense_unit;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        bit          is_rd;
        logic [15:0] mask;
        logic [15:0] val;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [7:0]  pin_async = 8'hFF;
    logic [7:0]  clr_strobe = '0;
    logic [7:0]  req;

    item_t sb_q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_sense_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .pin_async  (pin_async),
        .clr_strobe (clr_strobe),
        .req        (req)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic exp_req(input logic [7:0] mask, input logic [7:0] val, input string tag);
        item_t it;
        it.is_rd = 1'b0; it.mask = {8'h00, mask}; it.val = {8'h00, val}; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic exp_rd(input logic [15:0] val, input string tag);
        item_t it;
        it.is_rd = 1'b1; it.mask = 16'hFFFF; it.val = val; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic write_ctrl(input logic [15:0] v);
        wr_en = 1'b1;
        wr_data = v;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr(input int ch);
        clr_strobe[ch] = 1'b1;
        step(1);
        clr_strobe[ch] = 1'b0;
    endtask

    // monitor: compares queued expectations one time unit after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t       it;
                logic [15:0] act;
                it  = sb_q.pop_front();
                act = it.is_rd ? rd_data : {8'h00, req};
                n_chk++;
                if ((act & it.mask) !== (it.val & it.mask)) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act & it.mask, it.val & it.mask);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        step(1);
        exp_req(8'hFF, 8'h00, "R2 req low in reset");
        exp_rd(16'h0000, "R1 reset value");
        step(2);
        rst_n = 1'b1;
        step(3);
        exp_req(8'hFF, 8'h00, "R2 req low after reset");

        // R1 readback
        write_ctrl(16'hA5C3);
        exp_rd(16'hA5C3, "R1 readback");
        write_ctrl(16'h0000);
        exp_rd(16'h0000, "R1 readback zero");
        step(2);

        // R3 level mode on channel 2
        pin_async[2] = 1'b0;
        step(1);
        exp_req(8'h04, 8'h00, "R3 level one edge");
        step(1);
        exp_req(8'hFF, 8'h04, "R3 level asserted");
        pin_async[2] = 1'b1;
        step(2);
        exp_req(8'hFF, 8'h00, "R3 level released");

        // R4 falling on channel 5 (bits 11:10 = 01)
        write_ctrl(16'h0400);
        step(2);
        pin_async[5] = 1'b0;
        step(2);
        exp_req(8'h20, 8'h00, "R4 before third edge");
        step(1);
        exp_req(8'hFF, 8'h20, "R4 falling latched");
        step(5);
        exp_req(8'h20, 8'h20, "R7 hold");
        pin_async[5] = 1'b1;
        step(4);
        exp_req(8'h20, 8'h20, "R7 hold through rise");
        pulse_clr(5);
        exp_req(8'h20, 8'h00, "R7 clear drops");
        step(4);
        exp_req(8'h20, 8'h00, "R4 rise ignored");

        // R5 rising on channel 0 (bits 1:0 = 10)
        write_ctrl(16'h0402);
        step(2);
        pin_async[0] = 1'b0;
        step(4);
        exp_req(8'h01, 8'h00, "R5 fall ignored");
        pin_async[0] = 1'b1;
        step(2);
        exp_req(8'h01, 8'h00, "R5 before third edge");
        step(1);
        exp_req(8'h01, 8'h01, "R5 rising latched");

        // R6 both edges on channel 7 (bits 15:14 = 11)
        write_ctrl(16'hC402);
        step(2);
        pin_async[7] = 1'b0;
        step(3);
        exp_req(8'h80, 8'h80, "R6 fall latched");
        pulse_clr(7);
        exp_req(8'h80, 8'h00, "R6 cleared");
        pin_async[7] = 1'b1;
        step(3);
        exp_req(8'h80, 8'h80, "R6 rise latched");

        // R8 edge detection on the same edge as a clear
        pin_async[7] = 1'b0;
        step(2);
        clr_strobe[7] = 1'b1;
        step(1);
        clr_strobe[7] = 1'b0;
        exp_req(8'h80, 8'h80, "R8 edge beats clear");
        pulse_clr(7);
        exp_req(8'h80, 8'h00, "R8 later clear");
        exp_req(8'hFF, 8'h01, "R10 other flags intact");

        // R9 code change discards a latched flag
        pin_async[5] = 1'b0;
        step(3);
        exp_req(8'hFF, 8'h21, "R9 flag set before change");
        write_ctrl(16'hCC02);
        exp_req(8'hFF, 8'h01, "R9 flag cleared by change");
        step(4);
        exp_req(8'hFF, 8'h01, "R9 no spurious request");
        write_ctrl(16'hC002);
        exp_req(8'hFF, 8'h21, "R10 level switch leaves ch0");
        exp_rd(16'hC002, "R1 final word");
        step(2);

        done = 1'b1;
        step(1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule